// File: doc/BRIEF.md
# Register-Mapped Serial Port with Transmit and Receive Queues

This block is a byte-oriented asynchronous serial port that software drives through seven 32-bit word registers. Bytes to be sent go into an eight-entry transmit queue. A serializer drains the queue and sends each byte as a frame with one start bit, eight data bits and one stop bit, least significant bit first. A deserializer watches the incoming line, rebuilds the frames it sees and places the bytes in an eight-entry receive queue.

Status is folded into the data words. Reading the transmit word tells software whether the queue is full. Reading the receive word either pops a byte or reports that the queue is empty, so a single bus read both tests for data and takes it. A common divisor sets the bit time. Two level comparators, one per queue, drive a small pending register. A mask register decides which pending conditions reach the single interrupt line.

Bus accesses take one cycle. Read data is combinational from `bus_addr` while `bus_en` is high and `bus_we` is low. Writes and the receive pop take effect on that clock edge.

Top module: `uart_mmio`

## Requirements
- R1: Word index 0 is transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt mask, 5 pending (read-only) and 6 divisor. After reset these read 0x0, 0x80000000, 0x0, 0x0, 0x0, 0x0 and 0xF respectively, `txd` is 1 and `irq` is 0.
- R2: Reading index 0 returns bit 31 = 1 exactly when the transmit queue holds 8 bytes, with all other bits zero. A write to index 0 queues `bus_wdata[7:0]`. A write while the queue is full is dropped.
- R3: Reading index 1 with an empty receive queue returns 0x80000000 and changes nothing. Otherwise it returns the oldest byte in bits 7:0 with the other bits zero, and removes that byte. Bytes come out in arrival order.
- R4: While transmit control bit 0 is 0, no new frame starts, `txd` stays 1 and queued bytes are kept.
- R5: While receive control bit 0 is 0, frames on `rxd` are not captured.
- R6: The divisor register is 16 bits wide (bits 15:0 of index 6). Each transmitted bit lasts exactly divisor+1 clock cycles. A divisor of 0 gives one cycle per bit.
- R7: A transmitted frame is one low start bit, then the eight data bits least significant first, then one high stop bit. Queued bytes follow one another with no idle gap.
- R8: The receiver samples each bit near its middle and is specified for divisor values of 7 or more. A frame whose stop bit samples low is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: A byte that completes while the receive queue holds 8 bytes is discarded, and the queued bytes are kept.
- R10: Pending bit 0 is 1 when the transmit queue count is less than transmit control bits 18:16. Pending bit 1 is 1 when the receive queue count is greater than receive control bits 18:16.
- R11: `irq` is 1 exactly when some pending bit is 1 and the matching bit of interrupt mask bits 1:0 is 1. A mask of 0 silences `irq`.
- R12: Each queue holds at most 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Masked interrupt request |

## Verification
A queue pointer or count that drifts shows up quickly at the ports. The next loopback read returns a byte out of order, a stale byte, or a false empty or full flag. The pending bits move at the wrong fill level, and this is visible on the read that follows the push. A fault in the serializer's bit counter or in the divisor reload shows up within one frame. It changes how long `txd` stays low for the start bit, or it moves a data bit away from the mid-bit sample taken by the bench. A receiver that samples at the wrong phase or mishandles the stop bit corrupts the byte read after the next frame. It can also accept a frame that should have been dropped.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [2:0] {
    RA_TXDATA = 3'd0,
    RA_RXDATA = 3'd1,
    RA_TXCTRL = 3'd2,
    RA_RXCTRL = 3'd3,
    RA_IMASK  = 3'd4,
    RA_PEND   = 3'd5,
    RA_DIV    = 3'd6
  } reg_addr_e;

  localparam int unsigned LVL_W   = 3;
  localparam int unsigned LVL_LSB = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = BYTE_W + 2;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rp_q];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = do_push ? wrap_inc(wp_q) : wp_q;
    rp_d  = do_pop  ? wrap_inc(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  output logic          tick
);

  logic [DW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == '0);

  always_comb begin
    cnt_d = tick ? div : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              empty,
  input  logic [BYTE_W-1:0] din,
  output logic              pop,
  output logic              txd,
  output logic              busy
);

  localparam logic [3:0] LAST_BIT = 4'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [3:0]         bit_q, bit_d;
  logic               busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    pop    = 1'b0;
    if (tick) begin
      if (busy_q && bit_q != LAST_BIT) begin
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        bit_d = bit_q + 1'b1;
      end else if (en && !empty) begin
        sh_d   = {1'b1, din, 1'b0};
        bit_d  = '0;
        busy_d = 1'b1;
        pop    = 1'b1;
      end else begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DW-1:0]     div,
  input  logic              rxd,
  output logic              push,
  output logic [BYTE_W-1:0] dout
);

  logic        sync1_q, sync2_q;
  rx_state_e   st_q, st_d;
  logic [DW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [2:0]        bit_q, bit_d;
  logic              smp, line;

  assign line = sync2_q;
  assign smp  = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = smp ? cnt_q : cnt_q - 1'b1;
    sh_d  = sh_q;
    bit_d = bit_q;
    push  = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        cnt_d = cnt_q;
        if (en && !line) begin
          st_d  = RX_START;
          cnt_d = div >> 1;
        end
      end
      RX_START: begin
        if (smp) begin
          cnt_d = div;
          bit_d = '0;
          st_d  = line ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (smp) begin
          cnt_d = div;
          sh_d  = {line, sh_q[BYTE_W-1:1]};
          if (bit_q == 3'(BYTE_W - 1)) st_d = RX_STOP;
          else                         bit_d = bit_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (smp) begin
          if (line) begin
            push = 1'b1;
            st_d = RX_IDLE;
          end else begin
            st_d = RX_HOLD;
          end
        end
      end
      RX_HOLD: begin
        cnt_d = cnt_q;
        if (line) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      bit_q   <= '0;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
    end
  end

  assign dout = sh_q;

endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DIV_RESET = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        txd,
  input  logic        rxd,
  output logic        irq
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic             txen_q, txen_d, rxen_q, rxen_d;
  logic [LVL_W-1:0] txlvl_q, txlvl_d, rxlvl_q, rxlvl_d;
  logic [1:0]       ie_q, ie_d;
  logic [DIV_W-1:0] div_q, div_d;

  logic              wr_acc, rd_acc;
  logic              tx_push, tx_pop, tx_full, tx_empty, tx_busy;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
  logic [CW-1:0]     tx_count, rx_count;
  logic              tick;
  logic [1:0]        pend;
  logic              unused_wdata;

  assign wr_acc  = bus_en && bus_we;
  assign rd_acc  = bus_en && !bus_we;
  assign tx_push = wr_acc && (bus_addr == RA_TXDATA);
  assign rx_pop  = rd_acc && (bus_addr == RA_RXDATA) && !rx_empty;
  assign unused_wdata = ^{bus_wdata[31:LVL_LSB+LVL_W], bus_wdata[LVL_LSB-1:DIV_W]};

  always_comb begin
    txen_d  = txen_q;
    txlvl_d = txlvl_q;
    rxen_d  = rxen_q;
    rxlvl_d = rxlvl_q;
    ie_d    = ie_q;
    div_d   = div_q;
    if (wr_acc) begin
      unique case (bus_addr)
        RA_TXCTRL: begin
          txen_d  = bus_wdata[0];
          txlvl_d = bus_wdata[LVL_LSB +: LVL_W];
        end
        RA_RXCTRL: begin
          rxen_d  = bus_wdata[0];
          rxlvl_d = bus_wdata[LVL_LSB +: LVL_W];
        end
        RA_IMASK: ie_d  = bus_wdata[1:0];
        RA_DIV:   div_d = bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_q  <= 1'b0;
      txlvl_q <= '0;
      rxen_q  <= 1'b0;
      rxlvl_q <= '0;
      ie_q    <= '0;
      div_q   <= DIV_W'(DIV_RESET);
    end else begin
      txen_q  <= txen_d;
      txlvl_q <= txlvl_d;
      rxen_q  <= rxen_d;
      rxlvl_q <= rxlvl_d;
      ie_q    <= ie_d;
      div_q   <= div_d;
    end
  end

  assign pend[0] = tx_count < CW'(txlvl_q);
  assign pend[1] = rx_count > CW'(rxlvl_q);
  assign irq     = |(pend & ie_q);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_TXDATA: bus_rdata[31] = tx_full;
      RA_RXDATA: begin
        if (rx_empty) bus_rdata[31] = 1'b1;
        else          bus_rdata[BYTE_W-1:0] = rx_head;
      end
      RA_TXCTRL: begin
        bus_rdata[0] = txen_q;
        bus_rdata[LVL_LSB +: LVL_W] = txlvl_q;
      end
      RA_RXCTRL: begin
        bus_rdata[0] = rxen_q;
        bus_rdata[LVL_LSB +: LVL_W] = rxlvl_q;
      end
      RA_IMASK: bus_rdata[1:0] = ie_q;
      RA_PEND:  bus_rdata[1:0] = pend;
      RA_DIV:   bus_rdata[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  uart_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(bus_wdata[BYTE_W-1:0]),
    .pop(tx_pop), .dout(tx_head),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uart_baud #(.DW(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  uart_tx i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(txen_q),
    .empty(tx_empty), .din(tx_head), .pop(tx_pop),
    .txd(txd), .busy(tx_busy)
  );

  uart_rx #(.DW(DIV_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .en(rxen_q), .div(div_q),
    .rxd(rxd), .push(rx_push), .dout(rx_byte)
  );

endmodule

// File: rtl/uart_chk.sv
module uart_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [1:0]    ie,
  input logic          irq,
  input logic          txd,
  input logic          tx_busy
);

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  // a full transmit queue that is not drained stays full: extra writes are dropped
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH) && !tx_pop) |=> (tx_count == CW'(DEPTH)));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0 && !rx_push) |=> (rx_count == '0));

  assert_rx_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH) && !rx_pop) |=> (rx_count == CW'(DEPTH)));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie != 2'b00));

  assert_txd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

endmodule

bind uart_mmio uart_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_count(tx_count), .rx_count(rx_count),
  .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
  .ie(ie_q), .irq(irq), .txd(txd), .tx_busy(tx_busy)
);

// File: tb/test_uart_mmio.sv
`timescale 1ns/1ps
module test_uart_mmio;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, irq;
  logic        loop_sel = 1'b0;
  logic        drv_rxd = 1'b1;
  logic        rxd;
  int          tests = 0;
  int          fails = 0;

  assign rxd = loop_sel ? txd : drv_rxd;

  always #2 clk = ~clk;

  uart_mmio i_uart_mmio (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq(irq)
  );

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int dv);
    for (int i = 0; i < 10; i++) begin
      drv_rxd = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
      repeat (dv + 1) @(negedge clk);
    end
    drv_rxd = 1'b1;
  endtask

  task automatic wait_txd_low();
    for (int g = 0; g < 400 && txd !== 1'b0; g++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset values
    rd(3'd0, d); chk("R1 txdata", d, 32'h0);
    rd(3'd1, d); chk("R1 rxdata", d, 32'h8000_0000);
    rd(3'd2, d); chk("R1 txctrl", d, 32'h0);
    rd(3'd3, d); chk("R1 rxctrl", d, 32'h0);
    rd(3'd4, d); chk("R1 imask", d, 32'h0);
    rd(3'd5, d); chk("R1 pend", d, 32'h0);
    rd(3'd6, d); chk("R1 div", d, 32'd15);
    chk("R1 txd", 32'(txd), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);

    // R10 transmit level sweep over every fill count, transmitter off (R4, R2, R12)
    for (int k = 0; k <= 8; k++) begin
      for (int lvl = 0; lvl < 8; lvl++) begin
        wr(3'd2, 32'(lvl) << 16);
        rd(3'd5, d);
        chk("R10 tx level", d, (k < lvl) ? 32'd1 : 32'd0);
      end
      rd(3'd0, d);
      chk("R2 full flag", d, (k == 8) ? 32'h8000_0000 : 32'h0);
      if (k < 8) wr(3'd0, 32'h10 + 32'(k));
    end
    wr(3'd0, 32'hEE);
    wait_clk(60);
    chk("R4 txd held idle", 32'(txd), 32'd1);

    // loopback drain: order kept, dropped byte absent (R2, R3, R12)
    wr(3'd6, 32'd7);
    wr(3'd3, 32'h0007_0001);
    loop_sel = 1'b1;
    wr(3'd2, 32'h1);
    wait_clk(800);
    for (int k = 0; k < 8; k++) begin
      rd(3'd1, d); chk("R3 rx order", d, 32'h10 + 32'(k));
    end
    rd(3'd1, d); chk("R2 dropped write absent", d, 32'h8000_0000);
    rd(3'd1, d); chk("R3 empty read repeat", d, 32'h8000_0000);
    rd(3'd5, d); chk("R3 empty read no pop", d, 32'h0);

    // R9 receive queue overflow: 10 frames, first 8 kept
    for (int k = 0; k < 8; k++) wr(3'd0, 32'h20 + 32'(k));
    wait_clk(340);
    wr(3'd0, 32'h30);
    wr(3'd0, 32'h31);
    wait_clk(900);
    for (int k = 0; k < 8; k++) begin
      rd(3'd1, d); chk("R9 kept bytes", d, 32'h20 + 32'(k));
    end
    rd(3'd1, d); chk("R9 overflow discarded", d, 32'h8000_0000);

    // R10 / R11 receive level and masking
    wr(3'd3, 32'h0001_0001);
    wr(3'd0, 32'h41);
    wait_clk(100);
    rd(3'd5, d); chk("R10 rx level one byte", d, 32'h0);
    wr(3'd4, 32'h2);
    chk("R11 irq no pending", 32'(irq), 32'd0);
    wr(3'd0, 32'h42);
    wait_clk(100);
    rd(3'd5, d); chk("R10 rx level two bytes", d, 32'h2);
    chk("R11 irq rx enabled", 32'(irq), 32'd1);
    wr(3'd4, 32'h0);
    chk("R11 irq masked", 32'(irq), 32'd0);
    wr(3'd2, 32'h0001_0001);
    wr(3'd4, 32'h1);
    chk("R11 irq tx level", 32'(irq), 32'd1);
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd1, d); chk("R3 drain a", d, 32'h41);
    rd(3'd1, d); chk("R3 drain b", d, 32'h42);

    // R7 / R8 every byte value through the loop
    for (int b = 0; b < 256; b++) begin
      wr(3'd0, 32'(b));
      wait_clk(100);
      rd(3'd1, d); chk("R7 loopback byte", d, 32'(b));
    end

    // R7 frame shape sampled mid-bit at the pin
    loop_sel = 1'b0;
    foreach (d[i]) ;
    for (int s = 0; s < 3; s++) begin
      logic [7:0] b;
      b = (s == 0) ? 8'hA3 : (s == 1) ? 8'h00 : 8'hFF;
      wr(3'd0, {24'h0, b});
      wait_txd_low();
      wait_clk(4);
      for (int i = 0; i < 10; i++) begin
        chk("R7 frame bit", 32'(txd), (i == 0) ? 32'd0 : (i == 9) ? 32'd1 : 32'(b[i-1]));
        wait_clk(8);
      end
      wait_clk(10);
    end

    // R8 stop bit low: frame discarded, next good frame accepted
    send_frame(8'h5A, 1'b0, 7);
    wait_clk(30);
    rd(3'd1, d); chk("R8 bad stop dropped", d, 32'h8000_0000);
    send_frame(8'h5A, 1'b1, 7);
    wait_clk(20);
    rd(3'd1, d); chk("R8 good frame after bad", d, 32'h5A);

    // R5 receiver disabled
    wr(3'd3, 32'h0);
    send_frame(8'h3C, 1'b1, 7);
    wait_clk(20);
    rd(3'd1, d); chk("R5 rx disabled", d, 32'h8000_0000);
    wr(3'd3, 32'h1);

    // R6 start bit width for several divisors
    for (int s = 0; s < 4; s++) begin
      int dv;
      dv = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 2 : 5;
      wr(3'd6, 32'(dv));
      rd(3'd6, d); chk("R6 div readback", d, 32'(dv));
      wr(3'd0, 32'h55);
      wait_txd_low();
      n = 0;
      while (txd === 1'b0 && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk("R6 bit period", 32'(n), 32'(dv + 1));
      wait_clk(12 * (dv + 1) + 20);
    end

    report();
    $finish;
  end

endmodule